// File: doc/BRIEF.md
# Remote Memory Request Engine

This block is the communication assist of one node in a shared-address-space multiprocessor. The local processor hands it loads and stores that carry a global address. The upper bits of that address name the node that owns the word, and the lower bits give the offset inside that node's memory. The engine compares the node field with its own node number before it does anything on the network. A local access goes straight to the local memory port. A remote access becomes a request packet and is answered by a response packet: read data for a read, an acknowledge for a write. Only one processor access is in flight at a time, and the processor stalls until it completes.

The same engine also serves request packets that other nodes send here. It performs them on local memory without the local processor and returns a response packet. Requests that arrive are always drained, even while the engine's own outgoing request is stuck. Two rules make this work. A one-entry holding buffer keeps a finished response, and the transmit arbiter always sends that held response ahead of a new processor request. Incoming response packets are never refused.

Top module: `rmem_engine`

The processor-side machine has four states. C_IDLE accepts a request. C_LOCAL waits one cycle for memory read data. C_SEND offers the request packet. C_WAIT waits for the matching answer. Its transitions are:
- C_IDLE to C_LOCAL when a local access is taken.
- C_IDLE to C_SEND when a remote access is taken.
- C_LOCAL back to C_IDLE unconditionally.
- C_SEND to C_WAIT when the packet is transmitted.
- C_WAIT back to C_IDLE on a matching response.

The service machine has two states. S_IDLE takes a request packet. S_CAPT captures memory read data into the holding buffer. Its transitions are:
- S_IDLE to S_CAPT when a read request is taken.
- A write request leaves the machine in S_IDLE and fills the buffer at once.
- S_CAPT back to S_IDLE unconditionally.

## Requirements
- R1: An address whose top NODE_W bits equal NODE_ID is local. It drives the memory port in the accepting cycle, with the low OFF_W bits as the offset, and sends no packet. Any other address produces a request packet. That packet has type 0 (read) or 1 (write), src NODE_ID, dst equal to the node field, addr equal to the offset, and data equal to the write data (0 for a read).
- R2: A local access raises cpu_rsp_valid for one cycle, two clock edges after the edge that accepted it. cpu_rsp_rdata carries the memory read data for a read and 0 for a write. Memory read data arrives on the port one cycle after the request.
- R3: Only one access is outstanding. After a remote read request is sent, cpu_req_ready stays low until a type 2 response arrives. That response must come from the request's dst, be addressed to NODE_ID and carry the same addr. The edge that takes it produces a one-cycle cpu_rsp_valid with the packet data.
- R4: A remote write completes at the processor, with data 0, only on the edge after a matching type 3 acknowledge is taken. No response appears before that.
- R5: An incoming type 1 packet writes local memory. The engine returns a type 3 packet with src NODE_ID, dst equal to the requester, the same addr and data 0. An incoming type 0 packet reads local memory. The engine returns a type 2 packet with the read data.
- R6: Incoming request packets (type 0 or 1) are accepted whenever the holding buffer is empty and the service machine is idle, whatever the processor side is doing. Incoming response packets (type 2 or 3) are always accepted.
- R7: A held response goes out on the transmit port before any waiting processor request. While a held response is refused by the network, it stays offered and unchanged.
- R8: If an incoming request and a local processor access want memory in the same cycle, the incoming request gets the memory port. The processor access is not accepted in that cycle.
- R9: A response that does not match the pending remote access in type, source or address sets err_flag. Such a response produces no processor response. err_flag stays set until reset.
- R10: After reset, cpu_req_ready and net_rx_ready are high, and cpu_rsp_valid, net_tx_valid and err_flag are low.
- Packet layout (all requirements): bits [PKT_W-1:PKT_W-2] hold the type, then src, then dst (NODE_W bits each), then addr (OFF_W bits), with data in the low DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor access present |
| cpu_req_ready | output | 1 | Access taken on this edge when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | NODE_W+OFF_W | Global address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data (0 for stores) |
| mem_req_valid | output | 1 | Local memory access this cycle |
| mem_req_write | output | 1 | Memory write enable |
| mem_req_addr | output | OFF_W | Memory offset |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_rdata | input | DATA_W | Read data, one cycle after the request |
| net_tx_valid | output | 1 | Outgoing packet offered |
| net_tx_ready | input | 1 | Network takes the packet |
| net_tx_pkt | output | PKT_W | Outgoing packet |
| net_rx_valid | input | 1 | Incoming packet present |
| net_rx_ready | output | 1 | Engine takes the packet |
| net_rx_pkt | input | PKT_W | Incoming packet |
| err_flag | output | 1 | Sticky unmatched-response flag |

## Verification
Two collisions are provoked on purpose. In the first, the bench presents a local processor read and an incoming read request in the same cycle. It judges the result by cpu_req_ready staying low while net_rx_ready is high and the memory address belongs to the packet. The processor read must then be accepted the following cycle and still return its own data. In the second, the transmit port is held off while a processor remote read sits in C_SEND and an incoming request arrives. The incoming request must still be taken, and its response must leave first once the network accepts again. A queue-based model in the bench predicts every transmitted packet and every processor response, and compares them on each clock.

// File: rtl/rmem_pkg.sv
package rmem_pkg;
    typedef enum logic [1:0] {
        PK_RDREQ = 2'd0,
        PK_WRREQ = 2'd1,
        PK_RDRSP = 2'd2,
        PK_WRACK = 2'd3
    } pkt_kind_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_LOCAL = 2'd1,
        C_SEND  = 2'd2,
        C_WAIT  = 2'd3
    } cpu_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_CAPT = 1'b1
    } srv_state_e;
endpackage

// File: rtl/rmem_cpu_side.sv
module rmem_cpu_side
    import rmem_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter logic [NODE_W-1:0] NODE_ID = 2,
    localparam int ADDR_W = NODE_W + OFF_W,
    localparam int PKT_W  = 2 + 2*NODE_W + OFF_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    input  logic              mem_busy,
    output logic              loc_mem_valid,
    output logic              loc_mem_write,
    output logic [OFF_W-1:0]  loc_mem_addr,
    output logic [DATA_W-1:0] loc_mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              req_pkt_valid,
    output logic [PKT_W-1:0]  req_pkt,
    input  logic              req_taken,
    input  logic              rsp_in_valid,
    input  pkt_kind_e         rsp_in_kind,
    input  logic [NODE_W-1:0] rsp_in_src,
    input  logic [NODE_W-1:0] rsp_in_dst,
    input  logic [OFF_W-1:0]  rsp_in_off,
    input  logic [DATA_W-1:0] rsp_in_data,
    output logic              err_flag
);
    cpu_state_e st, st_n;

    logic              pend_write;
    logic [NODE_W-1:0] pend_dst;
    logic [OFF_W-1:0]  pend_off;
    logic [DATA_W-1:0] pend_data;
    logic              rsp_v;
    logic [DATA_W-1:0] rsp_d;
    logic              err_q;

    logic [NODE_W-1:0] req_node;
    logic [OFF_W-1:0]  req_off;
    logic              is_local;
    logic              fire;
    logic              rsp_match;
    pkt_kind_e         want_kind;

    assign req_node  = cpu_req_addr[ADDR_W-1 -: NODE_W];
    assign req_off   = cpu_req_addr[OFF_W-1:0];
    assign is_local  = (req_node == NODE_ID);
    assign fire      = cpu_req_valid && cpu_req_ready;
    assign want_kind = pend_write ? PK_WRACK : PK_RDRSP;
    assign rsp_match = (st == C_WAIT) && rsp_in_valid &&
                       (rsp_in_kind == want_kind) &&
                       (rsp_in_src == pend_dst) &&
                       (rsp_in_dst == NODE_ID) &&
                       (rsp_in_off == pend_off);

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            C_IDLE:  if (fire) st_n = is_local ? C_LOCAL : C_SEND;
            C_LOCAL: st_n = C_IDLE;
            C_SEND:  if (req_taken) st_n = C_WAIT;
            C_WAIT:  if (rsp_match) st_n = C_IDLE;
            default: st_n = C_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_n;
    end

    // outputs
    always_comb begin
        cpu_req_ready = (st == C_IDLE) && !(is_local && mem_busy);
        loc_mem_valid = cpu_req_valid && cpu_req_ready && is_local;
        loc_mem_write = cpu_req_write;
        loc_mem_addr  = req_off;
        loc_mem_wdata = cpu_req_wdata;
        req_pkt_valid = (st == C_SEND);
        req_pkt = {pend_write ? PK_WRREQ : PK_RDREQ, NODE_ID, pend_dst, pend_off,
                   pend_write ? pend_data : {DATA_W{1'b0}}};
        cpu_rsp_valid = rsp_v;
        cpu_rsp_rdata = rsp_d;
        err_flag      = err_q;
    end

    // pending access, completion and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_write <= 1'b0;
            pend_dst   <= '0;
            pend_off   <= '0;
            pend_data  <= '0;
            rsp_v      <= 1'b0;
            rsp_d      <= '0;
            err_q      <= 1'b0;
        end else begin
            rsp_v <= 1'b0;
            if (fire) begin
                pend_write <= cpu_req_write;
                pend_dst   <= req_node;
                pend_off   <= req_off;
                pend_data  <= cpu_req_wdata;
            end
            if (st == C_LOCAL) begin
                rsp_v <= 1'b1;
                rsp_d <= pend_write ? '0 : mem_rdata;
            end
            if (rsp_match) begin
                rsp_v <= 1'b1;
                rsp_d <= pend_write ? '0 : rsp_in_data;
            end
            if (rsp_in_valid && !rsp_match) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rmem_serve.sv
module rmem_serve
    import rmem_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter logic [NODE_W-1:0] NODE_ID = 2,
    localparam int PKT_W = 2 + 2*NODE_W + OFF_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  pkt_kind_e         in_kind,
    input  logic [NODE_W-1:0] in_src,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [DATA_W-1:0] in_data,
    output logic              can_take,
    output logic              take,
    output logic              srv_mem_write,
    output logic [OFF_W-1:0]  srv_mem_addr,
    output logic [DATA_W-1:0] srv_mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hold_valid,
    output logic [PKT_W-1:0]  hold_pkt,
    input  logic              hold_taken
);
    srv_state_e st, st_n;

    logic              hold_v;
    logic [PKT_W-1:0]  hold_q;
    logic [NODE_W-1:0] cap_src;
    logic [OFF_W-1:0]  cap_off;
    logic              is_wr;

    assign is_wr = (in_kind == PK_WRREQ);

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:  if (take && !is_wr) st_n = S_CAPT;
            S_CAPT:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // outputs
    always_comb begin
        can_take      = (st == S_IDLE) && !hold_v;
        take          = in_valid && can_take;
        srv_mem_write = is_wr;
        srv_mem_addr  = in_off;
        srv_mem_wdata = in_data;
        hold_valid    = hold_v;
        hold_pkt      = hold_q;
    end

    // holding buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v  <= 1'b0;
            hold_q  <= '0;
            cap_src <= '0;
            cap_off <= '0;
        end else begin
            if (hold_taken) hold_v <= 1'b0;
            if (take) begin
                cap_src <= in_src;
                cap_off <= in_off;
                if (is_wr) begin
                    hold_v <= 1'b1;
                    hold_q <= {PK_WRACK, NODE_ID, in_src, in_off, {DATA_W{1'b0}}};
                end
            end
            if (st == S_CAPT) begin
                hold_v <= 1'b1;
                hold_q <= {PK_RDRSP, NODE_ID, cap_src, cap_off, mem_rdata};
            end
        end
    end
endmodule

// File: rtl/rmem_tx_arb.sv
module rmem_tx_arb #(
    parameter int PKT_W = 54
) (
    input  logic             rsp_valid,
    input  logic [PKT_W-1:0] rsp_pkt,
    input  logic             req_valid,
    input  logic [PKT_W-1:0] req_pkt,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [PKT_W-1:0] tx_pkt,
    output logic             rsp_taken,
    output logic             req_taken
);
    always_comb begin
        tx_valid  = rsp_valid || req_valid;
        tx_pkt    = rsp_valid ? rsp_pkt : req_pkt;
        rsp_taken = rsp_valid && tx_ready;
        req_taken = !rsp_valid && req_valid && tx_ready;
    end
endmodule

// File: rtl/rmem_engine.sv
module rmem_engine
    import rmem_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter logic [NODE_W-1:0] NODE_ID = 2,
    localparam int ADDR_W = NODE_W + OFF_W,
    localparam int PKT_W  = 2 + 2*NODE_W + OFF_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [OFF_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              net_tx_valid,
    input  logic              net_tx_ready,
    output logic [PKT_W-1:0]  net_tx_pkt,
    input  logic              net_rx_valid,
    output logic              net_rx_ready,
    input  logic [PKT_W-1:0]  net_rx_pkt,
    output logic              err_flag
);
    pkt_kind_e         rx_kind;
    logic [NODE_W-1:0] rx_src, rx_dst;
    logic [OFF_W-1:0]  rx_off;
    logic [DATA_W-1:0] rx_data;
    logic              rx_is_rsp;

    assign rx_kind   = pkt_kind_e'(net_rx_pkt[PKT_W-1 -: 2]);
    assign rx_src    = net_rx_pkt[PKT_W-3 -: NODE_W];
    assign rx_dst    = net_rx_pkt[PKT_W-3-NODE_W -: NODE_W];
    assign rx_off    = net_rx_pkt[DATA_W+OFF_W-1 -: OFF_W];
    assign rx_data   = net_rx_pkt[DATA_W-1:0];
    assign rx_is_rsp = (rx_kind == PK_RDRSP) || (rx_kind == PK_WRACK);

    logic              srv_can_take, srv_take, srv_wr;
    logic [OFF_W-1:0]  srv_addr;
    logic [DATA_W-1:0] srv_wdata;
    logic              hold_v, hold_taken;
    logic [PKT_W-1:0]  hold_pkt;

    logic              loc_v, loc_wr;
    logic [OFF_W-1:0]  loc_addr;
    logic [DATA_W-1:0] loc_wdata;
    logic              req_v, req_taken;
    logic [PKT_W-1:0]  req_pkt;

    assign net_rx_ready = rx_is_rsp || srv_can_take;

    rmem_serve #(
        .NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)
    ) u_serve (
        .clk(clk), .rst_n(rst_n),
        .in_valid(net_rx_valid && !rx_is_rsp),
        .in_kind(rx_kind), .in_src(rx_src), .in_off(rx_off), .in_data(rx_data),
        .can_take(srv_can_take), .take(srv_take),
        .srv_mem_write(srv_wr), .srv_mem_addr(srv_addr), .srv_mem_wdata(srv_wdata),
        .mem_rdata(mem_rsp_rdata),
        .hold_valid(hold_v), .hold_pkt(hold_pkt), .hold_taken(hold_taken)
    );

    rmem_cpu_side #(
        .NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)
    ) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_busy(srv_take),
        .loc_mem_valid(loc_v), .loc_mem_write(loc_wr),
        .loc_mem_addr(loc_addr), .loc_mem_wdata(loc_wdata),
        .mem_rdata(mem_rsp_rdata),
        .req_pkt_valid(req_v), .req_pkt(req_pkt), .req_taken(req_taken),
        .rsp_in_valid(net_rx_valid && rx_is_rsp),
        .rsp_in_kind(rx_kind), .rsp_in_src(rx_src), .rsp_in_dst(rx_dst),
        .rsp_in_off(rx_off), .rsp_in_data(rx_data),
        .err_flag(err_flag)
    );

    rmem_tx_arb #(.PKT_W(PKT_W)) u_arb (
        .rsp_valid(hold_v), .rsp_pkt(hold_pkt),
        .req_valid(req_v), .req_pkt(req_pkt),
        .tx_ready(net_tx_ready),
        .tx_valid(net_tx_valid), .tx_pkt(net_tx_pkt),
        .rsp_taken(hold_taken), .req_taken(req_taken)
    );

    // memory port: incoming service wins
    always_comb begin
        mem_req_valid = srv_take || loc_v;
        mem_req_write = srv_take ? srv_wr    : loc_wr;
        mem_req_addr  = srv_take ? srv_addr  : loc_addr;
        mem_req_wdata = srv_take ? srv_wdata : loc_wdata;
    end
endmodule

// File: rtl/rmem_engine_chk.sv
module rmem_engine_chk #(
    parameter int NODE_W = 4,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter logic [NODE_W-1:0] NODE_ID = 2,
    localparam int ADDR_W = NODE_W + OFF_W,
    localparam int PKT_W  = 2 + 2*NODE_W + OFF_W + DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic              cpu_rsp_valid,
    input logic              mem_req_valid,
    input logic [OFF_W-1:0]  mem_req_addr,
    input logic              net_tx_valid,
    input logic              net_tx_ready,
    input logic [PKT_W-1:0]  net_tx_pkt,
    input logic              net_rx_valid,
    input logic              net_rx_ready,
    input logic [PKT_W-1:0]  net_rx_pkt,
    input logic              err_flag
);
    logic cpu_local_fire;
    assign cpu_local_fire = cpu_req_valid && cpu_req_ready &&
                            (cpu_req_addr[ADDR_W-1 -: NODE_W] == NODE_ID);

    assert_local_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_local_fire |-> mem_req_valid && (mem_req_addr == cpu_req_addr[OFF_W-1:0]));

    assert_local_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_local_fire |-> ##2 cpu_rsp_valid);

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && net_tx_ready && !net_tx_pkt[PKT_W-1]) |=> !cpu_req_ready);

    assert_rsp_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (net_rx_valid && net_rx_pkt[PKT_W-1]) |-> net_rx_ready);

    assert_held_rsp_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && !net_tx_ready && net_tx_pkt[PKT_W-1]) |=>
            (net_tx_valid && $stable(net_tx_pkt)));

    assert_mem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_local_fire |-> !(net_rx_valid && net_rx_ready && !net_rx_pkt[PKT_W-1]));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind rmem_engine rmem_engine_chk #(
    .NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_rsp_valid(cpu_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .net_tx_valid(net_tx_valid), .net_tx_ready(net_tx_ready), .net_tx_pkt(net_tx_pkt),
    .net_rx_valid(net_rx_valid), .net_rx_ready(net_rx_ready), .net_rx_pkt(net_rx_pkt),
    .err_flag(err_flag)
);

// File: tb/rmem_engine_bench.sv
module rmem_engine_bench;
    localparam int NODE_W = 4;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam logic [NODE_W-1:0] ME = 4'd2;
    localparam int ADDR_W = NODE_W + OFF_W;
    localparam int PKT_W  = 2 + 2*NODE_W + OFF_W + DATA_W;

    logic clk = 0, rst_n = 0;
    logic cpu_req_valid = 0, cpu_req_write = 0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic cpu_req_ready, cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_rdata;
    logic mem_req_valid, mem_req_write;
    logic [OFF_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata, mem_rsp_rdata;
    logic net_tx_valid, net_tx_ready = 1;
    logic [PKT_W-1:0] net_tx_pkt;
    logic net_rx_valid = 0, net_rx_ready;
    logic [PKT_W-1:0] net_rx_pkt = '0;
    logic err_flag;

    always #5 clk = ~clk;

    rmem_engine #(.NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .NODE_ID(ME)) u_rmem_engine (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_rdata(mem_rsp_rdata),
        .net_tx_valid(net_tx_valid), .net_tx_ready(net_tx_ready), .net_tx_pkt(net_tx_pkt),
        .net_rx_valid(net_rx_valid), .net_rx_ready(net_rx_ready), .net_rx_pkt(net_rx_pkt),
        .err_flag(err_flag)
    );

    // behavioural memory, one-cycle read latency
    logic [DATA_W-1:0] bmem [0:255];
    logic [DATA_W-1:0] rd_q = '0;
    assign mem_rsp_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_req_valid) begin
            if (mem_req_write) bmem[mem_req_addr[7:0]] <= mem_req_wdata;
            else               rd_q <= bmem[mem_req_addr[7:0]];
        end
    end

    int total = 0, bad = 0, cyc = 0;
    logic [PKT_W-1:0]  exp_tx[$];
    logic [DATA_W-1:0] exp_rsp[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PKT_W-1:0] mk(input logic [1:0] t, input logic [3:0] s,
            input logic [3:0] d, input logic [11:0] a, input logic [31:0] dat);
        return {t, s, d, a, dat};
    endfunction

    // per-clock model comparison (sampled at the falling edge)
    always @(negedge clk) begin
        if (rst_n && net_tx_valid && net_tx_ready) begin
            if (exp_tx.size() == 0) check(0, "R1/R5/R7 unexpected tx packet", 64'(net_tx_pkt), 0);
            else begin
                logic [PKT_W-1:0] e;
                e = exp_tx.pop_front();
                check(net_tx_pkt == e, "R1/R5/R7 tx packet", 64'(net_tx_pkt), 64'(e));
            end
        end
        if (rst_n && cpu_rsp_valid) begin
            if (exp_rsp.size() == 0) check(0, "R4/R9 unexpected cpu response", 64'(cpu_rsp_rdata), 0);
            else begin
                logic [DATA_W-1:0] e;
                e = exp_rsp.pop_front();
                check(cpu_rsp_rdata == e, "R2/R3 cpu response data", 64'(cpu_rsp_rdata), 64'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic sync();
        @(posedge clk); #2;
    endtask

    task automatic cpu_issue(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin @(posedge clk); #3; end
        sync();
        cpu_req_valid = 0;
    endtask

    task automatic rx_send(input logic [PKT_W-1:0] p);
        net_rx_valid = 1; net_rx_pkt = p;
        #1;
        while (!net_rx_ready) begin @(posedge clk); #3; end
        sync();
        net_rx_valid = 0;
    endtask

    task automatic drain(input string tag);
        repeat (4) sync();
        check(exp_tx.size() == 0 && exp_rsp.size() == 0, tag,
              64'(exp_tx.size() + exp_rsp.size()), 0);
    endtask

    initial begin
        repeat (3) sync();
        rst_n = 1;
        #1;
        // R10 reset state
        check(cpu_req_ready == 1, "R10 cpu_req_ready", 64'(cpu_req_ready), 1);
        check(net_rx_ready == 1, "R10 net_rx_ready", 64'(net_rx_ready), 1);
        check(cpu_rsp_valid == 0, "R10 cpu_rsp_valid", 64'(cpu_rsp_valid), 0);
        check(net_tx_valid == 0, "R10 net_tx_valid", 64'(net_tx_valid), 0);
        check(err_flag == 0, "R10 err_flag", 64'(err_flag), 0);
        sync();

        // R1/R2 local write then local read
        exp_rsp.push_back(32'h0);
        cpu_issue(1, 16'h2010, 32'hA5A5_0001);
        check(net_tx_valid == 0, "R1 local write sends no packet", 64'(net_tx_valid), 0);
        sync();
        exp_rsp.push_back(32'hA5A5_0001);
        cpu_issue(0, 16'h2010, 0);
        check(cpu_rsp_valid == 0, "R2 no response one edge after accept", 64'(cpu_rsp_valid), 0);
        sync();
        check(cpu_rsp_valid == 1, "R2 response two edges after accept", 64'(cpu_rsp_valid), 1);
        drain("R2 local queues drained");

        // R1/R3 remote read
        exp_tx.push_back(mk(2'd0, ME, 4'd5, 12'h020, 0));
        cpu_issue(0, 16'h5020, 0);
        sync();
        check(cpu_req_ready == 0, "R3 stall while remote read pending", 64'(cpu_req_ready), 0);
        exp_rsp.push_back(32'h1234_5678);
        rx_send(mk(2'd2, 4'd5, ME, 12'h020, 32'h1234_5678));
        check(cpu_rsp_valid == 1, "R3 response the edge after packet", 64'(cpu_rsp_valid), 1);
        drain("R3 queues drained");

        // R4 remote write waits for acknowledge
        exp_tx.push_back(mk(2'd1, ME, 4'd7, 12'h030, 32'h99));
        cpu_issue(1, 16'h7030, 32'h99);
        repeat (4) begin
            sync();
            check(cpu_rsp_valid == 0, "R4 no completion before ack", 64'(cpu_rsp_valid), 0);
        end
        exp_rsp.push_back(32'h0);
        rx_send(mk(2'd3, 4'd7, ME, 12'h030, 0));
        check(cpu_rsp_valid == 1, "R4 completion after ack", 64'(cpu_rsp_valid), 1);
        drain("R4 queues drained");

        // R5 incoming write then incoming read
        exp_tx.push_back(mk(2'd3, ME, 4'd9, 12'h040, 0));
        rx_send(mk(2'd1, 4'd9, ME, 12'h040, 32'hBEEF));
        drain("R5 write ack sent");
        check(bmem[8'h40] == 32'hBEEF, "R5 memory written by incoming request", 64'(bmem[8'h40]), 32'hBEEF);
        exp_tx.push_back(mk(2'd2, ME, 4'd9, 12'h040, 32'hBEEF));
        rx_send(mk(2'd0, 4'd9, ME, 12'h040, 0));
        drain("R5 read response sent");

        // R6/R7 outgoing path blocked, incoming request still served
        net_tx_ready = 0;
        cpu_issue(0, 16'h5044, 0);
        net_rx_valid = 1; net_rx_pkt = mk(2'd0, 4'd4, ME, 12'h010, 0);
        #1;
        check(net_rx_ready == 1, "R6 request taken while cpu request blocked", 64'(net_rx_ready), 1);
        sync();
        net_rx_valid = 0;
        sync(); sync();
        check(net_tx_pkt == mk(2'd2, ME, 4'd4, 12'h010, 32'hA5A5_0001),
              "R7 held response offered first", 64'(net_tx_pkt),
              64'(mk(2'd2, ME, 4'd4, 12'h010, 32'hA5A5_0001)));
        net_rx_valid = 1; net_rx_pkt = mk(2'd0, 4'd4, ME, 12'h014, 0);
        #1;
        check(net_rx_ready == 0, "R6 request refused while buffer full", 64'(net_rx_ready), 0);
        net_rx_pkt = mk(2'd3, 4'd6, ME, 12'h0, 0);
        #1;
        check(net_rx_ready == 1, "R6 response type always taken", 64'(net_rx_ready), 1);
        net_rx_valid = 0;
        exp_tx.push_back(mk(2'd2, ME, 4'd4, 12'h010, 32'hA5A5_0001));
        exp_tx.push_back(mk(2'd0, ME, 4'd5, 12'h044, 0));
        sync();
        net_tx_ready = 1;
        drain("R7 response then request");
        exp_rsp.push_back(32'h77);
        rx_send(mk(2'd2, 4'd5, ME, 12'h044, 32'h77));
        drain("R7 blocked read completed");

        // R8 memory conflict
        exp_tx.push_back(mk(2'd2, ME, 4'd9, 12'h010, 32'hA5A5_0001));
        exp_rsp.push_back(32'hBEEF);
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 16'h2040;
        net_rx_valid = 1; net_rx_pkt = mk(2'd0, 4'd9, ME, 12'h010, 0);
        #1;
        check(cpu_req_ready == 0, "R8 cpu access held off", 64'(cpu_req_ready), 0);
        check(net_rx_ready == 1, "R8 incoming request taken", 64'(net_rx_ready), 1);
        check(mem_req_addr == 12'h010, "R8 memory address from packet", 64'(mem_req_addr), 12'h010);
        sync();
        net_rx_valid = 0;
        #1;
        check(cpu_req_ready == 1, "R8 cpu access taken next cycle", 64'(cpu_req_ready), 1);
        sync();
        cpu_req_valid = 0;
        drain("R8 both served");

        // R9 mismatched response
        exp_tx.push_back(mk(2'd0, ME, 4'd5, 12'h060, 0));
        cpu_issue(0, 16'h5060, 0);
        sync();
        rx_send(mk(2'd2, 4'd6, ME, 12'h060, 32'hDEAD));
        check(err_flag == 1, "R9 wrong source sets error", 64'(err_flag), 1);
        check(cpu_rsp_valid == 0, "R9 no completion on mismatch", 64'(cpu_rsp_valid), 0);
        exp_rsp.push_back(32'h55);
        rx_send(mk(2'd2, 4'd5, ME, 12'h060, 32'h55));
        drain("R9 correct response completes");
        check(err_flag == 1, "R9 error stays set", 64'(err_flag), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule